// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block tracks status for the write sequencer of a NOR flash array. It accepts already-decoded commands: program, block erase, the two suspend flavours, resume and clear status. Along with each command it receives the lock flag of the addressed block, a supply-good level and the verify outcome of a stand-in array. An accepted program or erase runs as a loop. Each pulse takes one clock cycle and is followed by one verify cycle. The loop ends on a passing verify, on a supply fault, or when the pulse budget set by a parameter runs out.

The block presents an 8-bit status word and a ready line. Software polls the ready bit first and reads the error bits only after the block reports ready. A suspend parks the sequence and reports ready. The suspend flag then stays set until a resume continues the sequence from the step where it stopped. Error flags are sticky and are removed only by the clear-status command.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `status` reads 8'h80.
- R2: Command codes on `cmd` are: 1 program, 2 erase, 3 program suspend, 4 erase suspend, 5 resume, 6 clear status; 0 and 7 do nothing. A program or erase accepted while ready and not suspended holds `ready` and `status[7]` low. The operation runs as one pulse cycle followed by one verify cycle, so a verify pass on the first attempt gives exactly 2 busy cycles, with no error bit set.
- R3: If program verify fails on every attempt, the block gives up after PROG_PULSE_MAX attempts (2*PROG_PULSE_MAX busy cycles) and sets `status[4]`.
- R4: If erase verify fails on every attempt, the block gives up after ERASE_PULSE_MAX pulses (2*ERASE_PULSE_MAX busy cycles) and sets `status[5]`.
- R5: The supply level is sampled only when a program or erase is accepted and in each verify cycle. If it is low at acceptance, `status[3]` is set and the block never goes busy. If it is low in a verify cycle, the operation aborts with `status[3]`. A low level during a pulse cycle alone has no effect.
- R6: A program or erase with `blk_locked` high sets `status[1]`, starts nothing, and leaves `ready` at 1. The lock check takes priority over the supply check.
- R7: A program suspend during a program, or an erase suspend during an erase, raises `ready` and `status[7]` in the next cycle. It also sets `status[2]` for a program or `status[6]` for an erase. A suspend of the other kind is ignored.
- R8: Resume while suspended clears the suspend bit and `status[7]` in the next cycle and continues from the halted step: a sequence halted in its verify cycle needs exactly 1 more busy cycle. Resume with nothing suspended changes nothing.
- R9: Error bits 5, 4, 3 and 1 are sticky. A later successful operation keeps them. Clear status, accepted while ready, zeroes all four.
- R10: While busy, every command other than the matching suspend is ignored, including clear status and a new program or erase.
- R11: `status[0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd | input | 3 | Decoded command code |
| blk_locked | input | 1 | Lock flag of the targeted block |
| vpp_ok | input | 1 | Programming supply good |
| verify_pass | input | 1 | Array verify result, sampled in verify cycles |
| ready | output | 1 | 1 when ready or suspended, 0 while busy |
| status | output | 8 | Status word |

## Verification
The bench measures exact busy-cycle counts. An off-by-one pulse budget shows up as a wrong failure length. A resume that restarts the loop instead of continuing shows up as a verify-halted resume lasting 2 cycles instead of 1. The bench drops the supply only during a pulse cycle, which catches a design that samples the supply continuously by setting the supply error. It issues clear status and a fresh erase in mid-operation, which catches a design that does not gate commands while busy by losing a sticky bit or starting a new run. A locked block with a low supply is used to check that the lock check wins.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP        = 3'd0,
        CMD_PROG       = 3'd1,
        CMD_ERASE      = 3'd2,
        CMD_SUSP_PROG  = 3'd3,
        CMD_SUSP_ERASE = 3'd4,
        CMD_RESUME     = 3'd5,
        CMD_CLEAR      = 3'd6,
        CMD_RSVD       = 3'd7
    } fsc_cmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_PULSE  = 2'd1,
        SQ_VERIFY = 2'd2,
        SQ_SUSP   = 2'd3
    } fsc_seq_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } fsc_op_e;

    // indices into the sticky error vector
    localparam int ERR_LOCK  = 0;
    localparam int ERR_VPP   = 1;
    localparam int ERR_PROG  = 2;
    localparam int ERR_ERASE = 3;
    localparam int ERR_N     = 4;

    typedef struct packed {
        logic    start;
        fsc_op_e start_op;
        logic    suspend;
        logic    resume;
        logic    clear;
    } fsc_act_t;

    function automatic logic is_busy(fsc_seq_e s);
        return (s == SQ_PULSE) || (s == SQ_VERIFY);
    endfunction

    function automatic logic [7:0] pack_status(fsc_seq_e s, fsc_op_e op,
                                               logic [ERR_N-1:0] err);
        logic [7:0] w;
        w    = '0;
        w[7] = !is_busy(s);
        w[6] = (s == SQ_SUSP) && (op == OP_ERASE);
        w[5] = err[ERR_ERASE];
        w[4] = err[ERR_PROG];
        w[3] = err[ERR_VPP];
        w[2] = (s == SQ_SUSP) && (op == OP_PROG);
        w[1] = err[ERR_LOCK];
        return w;
    endfunction

endpackage

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
    import fsc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  fsc_seq_e   state,
    input  fsc_op_e    op,
    output fsc_act_t   act
);
    fsc_cmd_e c;

    always_comb begin
        c   = fsc_cmd_e'(cmd);
        act = '0;
        if (cmd_valid) begin
            unique case (c)
                CMD_PROG: begin
                    act.start    = (state == SQ_IDLE);
                    act.start_op = OP_PROG;
                end
                CMD_ERASE: begin
                    act.start    = (state == SQ_IDLE);
                    act.start_op = OP_ERASE;
                end
                CMD_SUSP_PROG:  act.suspend = is_busy(state) && (op == OP_PROG);
                CMD_SUSP_ERASE: act.suspend = is_busy(state) && (op == OP_ERASE);
                CMD_RESUME:     act.resume  = (state == SQ_SUSP);
                CMD_CLEAR:      act.clear   = !is_busy(state);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fsc_sequencer.sv
module fsc_sequencer
    import fsc_pkg::*;
#(
    parameter int ERASE_PULSE_MAX = 4,
    parameter int PROG_PULSE_MAX  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  fsc_act_t         act,
    input  logic             blk_locked,
    input  logic             vpp_ok,
    input  logic             verify_pass,
    output fsc_seq_e         state,
    output fsc_op_e          op,
    output logic [ERR_N-1:0] err_set
);
    localparam int MAX_LIM = (ERASE_PULSE_MAX > PROG_PULSE_MAX) ?
                             ERASE_PULSE_MAX : PROG_PULSE_MAX;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] E_LIM = CNT_W'(ERASE_PULSE_MAX);
    localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PROG_PULSE_MAX);

    fsc_seq_e         resume_st;
    logic [CNT_W-1:0] pulses;
    logic [CNT_W-1:0] limit;
    logic             exhausted;
    logic             vfy_step;

    assign limit     = (op == OP_ERASE) ? E_LIM : P_LIM;
    assign exhausted = (pulses >= limit);
    assign vfy_step  = (state == SQ_VERIFY) && !act.suspend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            op        <= OP_PROG;
            pulses    <= '0;
            resume_st <= SQ_PULSE;
        end else begin
            unique case (state)
                SQ_IDLE: if (act.start) begin
                    op <= act.start_op;
                    if (!blk_locked && vpp_ok) begin
                        state  <= SQ_PULSE;
                        pulses <= '0;
                    end
                end
                SQ_PULSE: if (act.suspend) begin
                    state     <= SQ_SUSP;
                    resume_st <= SQ_PULSE;
                end else begin
                    pulses <= pulses + 1'b1;
                    state  <= SQ_VERIFY;
                end
                SQ_VERIFY: if (act.suspend) begin
                    state     <= SQ_SUSP;
                    resume_st <= SQ_VERIFY;
                end else if (!vpp_ok || verify_pass || exhausted) begin
                    state <= SQ_IDLE;
                end else begin
                    state <= SQ_PULSE;
                end
                SQ_SUSP: if (act.resume) state <= resume_st;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        err_set = '0;
        if (state == SQ_IDLE && act.start) begin
            err_set[ERR_LOCK] = blk_locked;
            err_set[ERR_VPP]  = !blk_locked && !vpp_ok;
        end
        if (vfy_step) begin
            err_set[ERR_VPP] = !vpp_ok;
            if (vpp_ok && !verify_pass && exhausted) begin
                err_set[ERR_PROG]  = (op == OP_PROG);
                err_set[ERR_ERASE] = (op == OP_ERASE);
            end
        end
    end
endmodule

// File: rtl/fsc_err_flags.sv
module fsc_err_flags
    import fsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ERR_N-1:0] set,
    output logic [ERR_N-1:0] flags
);
    for (genvar i = 0; i < ERR_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clear) flags[i] <= 1'b0;
            else if (set[i])  flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsc_pkg::*;
#(
    parameter int ERASE_PULSE_MAX = 4,
    parameter int PROG_PULSE_MAX  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  logic       blk_locked,
    input  logic       vpp_ok,
    input  logic       verify_pass,
    output logic       ready,
    output logic [7:0] status
);
    fsc_seq_e         state;
    fsc_op_e          op;
    fsc_act_t         act;
    logic [ERR_N-1:0] err_set;
    logic [ERR_N-1:0] err;

    fsc_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .state     (state),
        .op        (op),
        .act       (act)
    );

    fsc_sequencer #(
        .ERASE_PULSE_MAX (ERASE_PULSE_MAX),
        .PROG_PULSE_MAX  (PROG_PULSE_MAX)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .blk_locked  (blk_locked),
        .vpp_ok      (vpp_ok),
        .verify_pass (verify_pass),
        .state       (state),
        .op          (op),
        .err_set     (err_set)
    );

    fsc_err_flags u_err (
        .clk   (clk),
        .rst   (rst),
        .clear (act.clear),
        .set   (err_set),
        .flags (err)
    );

    assign status = pack_status(state, op, err);
    assign ready  = status[7];
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd,
    input logic       blk_locked,
    input logic       vpp_ok,
    input logic       ready,
    input logic [7:0] status
);
    logic idle_free;
    logic start_cmd;
    assign idle_free = status[7] && !status[6] && !status[2];
    assign start_cmd = cmd_valid && (cmd == 3'd1 || cmd == 3'd2);

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        status[0] == 1'b0);

    p_susp_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (status[6] || status[2]) |-> status[7]);

    p_lock_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (idle_free && start_cmd && blk_locked) |=> (status[1] && ready));

    p_vpp_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (idle_free && start_cmd && !blk_locked && !vpp_ok) |=> (status[3] && ready));

    p_sticky_prog_r9: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !(cmd_valid && cmd == 3'd6 && ready)) |=> status[4]);

    p_sticky_erase_r10: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !ready) |=> status[5]);

    p_resume_r8: assert property (@(posedge clk) disable iff (rst)
        (status[2] && cmd_valid && cmd == 3'd5) |=> (!status[2] && !ready));
endmodule

bind flash_status_ctrl fsc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .blk_locked (blk_locked),
    .vpp_ok     (vpp_ok),
    .ready      (ready),
    .status     (status)
);

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
    localparam int EMAX = 4;
    localparam int PMAX = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       blk_locked = 1'b0;
    logic       vpp_ok = 1'b1;
    logic       verify_pass = 1'b1;
    logic       ready;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    flash_status_ctrl #(.ERASE_PULSE_MAX(EMAX), .PROG_PULSE_MAX(PMAX)) i_flash_status_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .blk_locked(blk_locked), .vpp_ok(vpp_ok), .verify_pass(verify_pass),
        .ready(ready), .status(status)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] c);
        cmd_valid = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd = 3'd0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        issue(3'd6);
        check("R9 clear", status, 8'h80);
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h80);
        check("R1 ready", ready, 1);
    endtask

    task automatic t_prog_pass();
        int n;
        verify_pass = 1'b1;
        issue(3'd1);
        check("R2 busy status7", status[7], 0);
        busy_len(n);
        check("R2 busy cycles", n, 2);
        check("R2 status", status, 8'h80);
    endtask

    task automatic t_prog_fail();
        int n;
        verify_pass = 1'b0;
        issue(3'd1);
        busy_len(n);
        check("R3 busy cycles", n, 2 * PMAX);
        check("R3 status", status, 8'h90);
        verify_pass = 1'b1;
        issue(3'd1);
        busy_len(n);
        check("R9 sticky after pass", status, 8'h90);
        clear_all();
    endtask

    task automatic t_erase_fail();
        int n;
        verify_pass = 1'b0;
        issue(3'd2);
        busy_len(n);
        check("R4 busy cycles", n, 2 * EMAX);
        check("R4 status", status, 8'hA0);
        verify_pass = 1'b1;
        clear_all();
    endtask

    task automatic t_vpp();
        int n;
        vpp_ok = 1'b0;
        issue(3'd1);
        check("R5 entry ready", ready, 1);
        check("R5 entry status", status, 8'h88);
        vpp_ok = 1'b1;
        clear_all();
        // low only during the pulse cycle
        verify_pass = 1'b1;
        issue(3'd2);
        vpp_ok = 1'b0;
        @(negedge clk);
        vpp_ok = 1'b1;
        busy_len(n);
        check("R5 pulse-only low ignored", status, 8'h80);
        // low in the verify cycle aborts
        verify_pass = 1'b0;
        issue(3'd2);
        @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        vpp_ok = 1'b1;
        check("R5 verify abort", status, 8'h88);
        verify_pass = 1'b1;
        clear_all();
    endtask

    task automatic t_lock();
        blk_locked = 1'b1;
        vpp_ok = 1'b0;
        issue(3'd2);
        check("R6 ready", ready, 1);
        check("R6 status lock wins", status, 8'h82);
        @(negedge clk);
        check("R6 stays ready", ready, 1);
        blk_locked = 1'b0;
        vpp_ok = 1'b1;
        clear_all();
    endtask

    task automatic t_suspend_prog();
        int n;
        verify_pass = 1'b1;
        issue(3'd1);
        issue(3'd4);
        check("R7 wrong suspend ignored", status, 8'h00);
        busy_len(n);
        check("R7 wrong suspend no delay", n, 1);
        issue(3'd1);
        issue(3'd3);
        check("R7 prog suspended", status, 8'h84);
        repeat (3) @(negedge clk);
        check("R7 suspend holds", status, 8'h84);
        issue(3'd5);
        check("R8 resume clears", status, 8'h00);
        busy_len(n);
        check("R8 resume from pulse", n, 2);
        check("R8 end status", status, 8'h80);
    endtask

    task automatic t_suspend_erase();
        int n;
        verify_pass = 1'b1;
        issue(3'd2);
        @(negedge clk);
        issue(3'd4);
        check("R7 erase suspended", status, 8'hC0);
        issue(3'd5);
        check("R8 erase resumed", status, 8'h00);
        busy_len(n);
        check("R8 resume from verify", n, 1);
    endtask

    task automatic t_resume_idle();
        issue(3'd5);
        check("R8 resume idle ignored", status, 8'h80);
    endtask

    task automatic t_busy_ignore();
        int n;
        verify_pass = 1'b0;
        issue(3'd1);
        busy_len(n);
        check("R10 setup", status, 8'h90);
        verify_pass = 1'b1;
        issue(3'd1);
        issue(3'd6);
        issue(3'd2);
        check("R10 ready after op", ready, 1);
        check("R10 clear ignored while busy", status, 8'h90);
        @(negedge clk);
        check("R10 erase not started", ready, 1);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prog_pass();
        t_prog_fail();
        t_erase_fail();
        t_vpp();
        t_lock();
        t_suspend_prog();
        t_suspend_erase();
        t_resume_idle();
        t_busy_ignore();
        check("R11 reserved bit", status[0], 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule